// File: doc/BRIEF.md
# Byte-Lane Enable Write Sequencer

This block sits between several register-write requesters and a register block whose bus carries no byte strobes. The target selects its byte lanes through a separate, sticky lane-enable control register. Each accepted write therefore becomes two ordered bus transactions. The first loads the control register with the lane enables that match the write's size and address. The second performs the data write itself.

A round-robin arbiter picks one requester at a time. The grant stays locked until the data write of the pair has been acknowledged, so no other requester can change the lane enables between the two steps. Straight after reset, and before any request is accepted, the block writes the control register once with all four lanes enabled.

A request is a word address, a data word and a size code. Sub-word data is presented right-justified, and the block moves it into the lanes that the address selects. A halfword request whose offset would cross the word boundary is accepted and dropped, and this is flagged to the requester.

Top module: `lanewr_seq`

## Requirements
- R1: After reset, the block issues one control write of value 0x78 (lanes 0..3 enabled in bits [6:3], all other bits zero) and raises no `reqReady` until that write is acknowledged.
- R2: An accepted, well-formed request drives `ctlWrEn` in the cycle after acceptance. `dataWrEn` rises only in the cycle after the control write is acknowledged. The two enables are never high together.
- R3: For size code 0 (byte) the lane mask is 1 shifted left by address bits [1:0]. For size code 1 (halfword) it is 2'b11 shifted left by address bits [1:0]. Lane mask bit n is placed in control bit n+3, and bits [2:0] are always zero.
- R4: For size code 2 or 3 (word), the control value has bits [7:3] all set (0xF8), whatever the address.
- R5: The data write carries the request's address and size code unchanged. Byte data [7:0] is moved to bit 8·a and halfword data [15:0] to bit 8·a, where a is address bits [1:0]; all other bits are zero. Word data passes unchanged.
- R6: A halfword request with address bits [1:0] equal to 3 is accepted (`reqReady`) together with a `reqDrop` pulse on the same requester bit. It produces neither a control write nor a data write.
- R7: At most one `reqReady` bit is high in any cycle. No `reqReady` is raised while a control or data write is pending, so no request is taken between the two steps of a pair.
- R8: When several requesters wait, the grant goes to the first valid requester after the one served last, in cyclic index order. After reset, requester 0 has first priority.
- R9: While a control or data write waits for its acknowledge, its enable and its payload stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | NREQ | Per-requester write request valid |
| reqAddr | input | NREQ*ADDR_W | Packed per-requester byte addresses |
| reqData | input | NREQ*DATA_W | Packed per-requester write data, sub-word values right-justified |
| reqSize | input | 2*NREQ | Packed size codes: 0 byte, 1 halfword, 2 or 3 word |
| reqReady | output | NREQ | One-hot acceptance strobe |
| reqDrop | output | NREQ | Pulses with `reqReady` when the accepted request is dropped as misaligned |
| ctlWrEn | output | 1 | Control-register write request |
| ctlWrData | output | LANE_LSB+DATA_W/8+1 | Control-register write value |
| ctlWrAck | input | 1 | Control write accepted by the target |
| dataWrEn | output | 1 | Data write request |
| dataWrAddr | output | ADDR_W | Data write address |
| dataWrData | output | DATA_W | Data write value, lane-placed |
| dataWrSize | output | 2 | Data write size code |
| dataWrAck | input | 1 | Data write accepted by the target |

## Verification
The bench writes at every byte offset and every legal halfword offset, and uses both word size codes at an unaligned address. A design that mis-shifts the lane mask or the data, or that forgets the fifth control bit for a word, would log a wrong control or data value. A halfword at offset 3 must vanish without touching the bus; a design that forwarded it would emit a control write whose mask spills past lane 3. With slow acknowledges and several requesters waiting together, a lock that released too early would let a second control write in before a pending data write, and a fixed-priority arbiter would serve requesters in a different order from the expected rotation.

// File: rtl/lanewr_pkg.sv
`timescale 1ns/1ps
package lanewr_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic initPhase;  // power-up control write in progress
    logic load;       // capture the granted request
    logic ctlPhase;   // control-register write on the bus
    logic dataPhase;  // data write on the bus
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_CTL  = 2'd2,
    ST_DATA = 2'd3
  } seqState_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/lanewr_arb.sv
`timescale 1ns/1ps
module lanewr_arb #(
  parameter int NREQ  = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NREQ-1:0]  reqValid,
  input  logic             enable,
  input  logic             advance,
  output logic [NREQ-1:0]  grant,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyGrant
);

  logic [IDX_W-1:0] lastIdx;

  // Search starts one past the last winner and wraps around
  always_comb begin
    int cand;
    anyGrant = 1'b0;
    grantIdx = '0;
    for (int off = 1; off <= NREQ; off++) begin
      cand = int'(lastIdx) + off;
      if (cand >= NREQ) cand = cand - NREQ;
      if (enable && !anyGrant && reqValid[cand]) begin
        anyGrant = 1'b1;
        grantIdx = IDX_W'(cand);
      end
    end
    grant = anyGrant ? (NREQ'(1) << grantIdx) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lastIdx <= IDX_W'(NREQ - 1);
    else if (advance) lastIdx <= grantIdx;
  end

endmodule

// File: rtl/lanewr_ctrl.sv
`timescale 1ns/1ps
module lanewr_ctrl
  import lanewr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyGrant,
  input  logic       selMisalign,
  input  logic       ctlWrAck,
  input  logic       dataWrAck,
  output seqStrobe_t strobe,
  output logic       arbEnable,
  output logic       accept,
  output logic       drop
);

  seqState_e state, nextState;

  always_comb begin
    strobe    = '0;
    arbEnable = 1'b0;
    accept    = 1'b0;
    drop      = 1'b0;
    nextState = state;
    case (state)
      ST_INIT: begin
        strobe.initPhase = 1'b1;
        strobe.ctlPhase  = 1'b1;
        if (ctlWrAck) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        arbEnable = 1'b1;
        if (anyGrant) begin
          accept = 1'b1;
          if (selMisalign) begin
            drop = 1'b1;
          end else begin
            strobe.load = 1'b1;
            nextState   = ST_CTL;
          end
        end
      end
      ST_CTL: begin
        strobe.ctlPhase = 1'b1;
        if (ctlWrAck) nextState = ST_DATA;
      end
      ST_DATA: begin
        strobe.dataPhase = 1'b1;
        if (dataWrAck) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT;
    else       state <= nextState;
  end

endmodule

// File: rtl/lanewr_dp.sv
`timescale 1ns/1ps
module lanewr_dp
  import lanewr_pkg::*;
#(
  parameter int NREQ     = 3,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int LANE_LSB = 3,
  parameter int IDX_W    = 2,
  localparam int LANES   = DATA_W / 8,
  localparam int CTL_W   = LANE_LSB + LANES + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [NREQ*ADDR_W-1:0] reqAddr,
  input  logic [NREQ*DATA_W-1:0] reqData,
  input  logic [NREQ*2-1:0]      reqSize,
  input  logic [IDX_W-1:0]       grantIdx,
  output logic                   selMisalign,
  output logic [CTL_W-1:0]       ctlWrData,
  output logic [ADDR_W-1:0]      dataWrAddr,
  output logic [DATA_W-1:0]      dataWrData,
  output logic [1:0]             dataWrSize
);

  localparam int OFS_W = $clog2(LANES);
  localparam logic [CTL_W-1:0] INIT_CTL = CTL_W'(((1 << LANES) - 1) << LANE_LSB);
  localparam logic [CTL_W-1:0] WORD_CTL = CTL_W'(((1 << (LANES + 1)) - 1) << LANE_LSB);

  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic [1:0]        selSize;
  logic [OFS_W-1:0]  ofs;
  logic [LANES-1:0]  laneMask;
  logic [CTL_W-1:0]  ctlNext;
  logic [DATA_W-1:0] placed;

  logic [CTL_W-1:0]  ctlReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [1:0]        sizeReg;

  assign selAddr = reqAddr[int'(grantIdx)*ADDR_W +: ADDR_W];
  assign selData = reqData[int'(grantIdx)*DATA_W +: DATA_W];
  assign selSize = reqSize[int'(grantIdx)*2 +: 2];
  assign ofs     = selAddr[OFS_W-1:0];

  always_comb begin
    case (selSize)
      SZ_BYTE: laneMask = LANES'(1) << ofs;
      SZ_HALF: laneMask = LANES'(3) << ofs;
      default: laneMask = '1;
    endcase
  end

  assign selMisalign = (selSize == SZ_HALF) && (ofs == OFS_W'(LANES - 1));
  assign ctlNext     = selSize[1] ? WORD_CTL : (CTL_W'(laneMask) << LANE_LSB);

  // Per-lane source selection for the data write
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      case (selSize)
        SZ_BYTE: placed[8*j +: 8] = (int'(ofs) == j) ? selData[7:0] : 8'h00;
        SZ_HALF: begin
          if (int'(ofs) == j)          placed[8*j +: 8] = selData[7:0];
          else if (int'(ofs) + 1 == j) placed[8*j +: 8] = selData[15:8];
          else                         placed[8*j +: 8] = 8'h00;
        end
        default: placed[8*j +: 8] = selData[8*j +: 8];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
      sizeReg <= '0;
    end else if (strobe.load) begin
      ctlReg  <= ctlNext;
      addrReg <= selAddr;
      dataReg <= placed;
      sizeReg <= selSize;
    end
  end

  // Outputs are quiet outside their own phase
  assign ctlWrData  = !strobe.ctlPhase ? '0 : (strobe.initPhase ? INIT_CTL : ctlReg);
  assign dataWrAddr = strobe.dataPhase ? addrReg : '0;
  assign dataWrData = strobe.dataPhase ? dataReg : '0;
  assign dataWrSize = strobe.dataPhase ? sizeReg : '0;

endmodule

// File: rtl/lanewr_seq.sv
`timescale 1ns/1ps
module lanewr_seq
  import lanewr_pkg::*;
#(
  parameter int NREQ     = 3,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int LANE_LSB = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NREQ-1:0]              reqValid,
  input  logic [NREQ*ADDR_W-1:0]       reqAddr,
  input  logic [NREQ*DATA_W-1:0]       reqData,
  input  logic [NREQ*2-1:0]            reqSize,
  output logic [NREQ-1:0]              reqReady,
  output logic [NREQ-1:0]              reqDrop,
  output logic                         ctlWrEn,
  output logic [LANE_LSB+DATA_W/8:0]   ctlWrData,
  input  logic                         ctlWrAck,
  output logic                         dataWrEn,
  output logic [ADDR_W-1:0]            dataWrAddr,
  output logic [DATA_W-1:0]            dataWrData,
  output logic [1:0]                   dataWrSize,
  input  logic                         dataWrAck
);

  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  seqStrobe_t       strobe;
  logic             arbEnable, accept, drop, anyGrant, selMisalign;
  logic [NREQ-1:0]  grant;
  logic [IDX_W-1:0] grantIdx;

  lanewr_arb #(.NREQ(NREQ), .IDX_W(IDX_W)) u_arb (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .enable   (arbEnable),
    .advance  (accept),
    .grant    (grant),
    .grantIdx (grantIdx),
    .anyGrant (anyGrant)
  );

  lanewr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .anyGrant    (anyGrant),
    .selMisalign (selMisalign),
    .ctlWrAck    (ctlWrAck),
    .dataWrAck   (dataWrAck),
    .strobe      (strobe),
    .arbEnable   (arbEnable),
    .accept      (accept),
    .drop        (drop)
  );

  lanewr_dp #(
    .NREQ(NREQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LANE_LSB(LANE_LSB), .IDX_W(IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .reqSize     (reqSize),
    .grantIdx    (grantIdx),
    .selMisalign (selMisalign),
    .ctlWrData   (ctlWrData),
    .dataWrAddr  (dataWrAddr),
    .dataWrData  (dataWrData),
    .dataWrSize  (dataWrSize)
  );

  assign reqReady = grant & {NREQ{accept}};
  assign reqDrop  = grant & {NREQ{drop}};
  assign ctlWrEn  = strobe.ctlPhase;
  assign dataWrEn = strobe.dataPhase;

endmodule

// File: rtl/lanewr_seq_chk.sv
`timescale 1ns/1ps
module lanewr_seq_chk #(
  parameter int NREQ     = 3,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int LANE_LSB = 3,
  localparam int CTL_W   = LANE_LSB + DATA_W / 8 + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NREQ-1:0]   reqReady,
  input logic [NREQ-1:0]   reqDrop,
  input logic              ctlWrEn,
  input logic [CTL_W-1:0]  ctlWrData,
  input logic              ctlWrAck,
  input logic              dataWrEn,
  input logic [ADDR_W-1:0] dataWrAddr,
  input logic [DATA_W-1:0] dataWrData,
  input logic              dataWrAck
);

  localparam logic [CTL_W-1:0] INIT_VAL = CTL_W'(((1 << (DATA_W / 8)) - 1) << LANE_LSB);

  logic seenAccept;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          seenAccept <= 1'b0;
    else if (|reqReady) seenAccept <= 1'b1;
  end

  AST_INIT_CTL: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !seenAccept) |-> ctlWrData == INIT_VAL); // R1

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctlWrEn && dataWrEn)); // R2

  AST_DATA_AFTER_CTL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataWrEn) |-> $past(ctlWrEn && ctlWrAck)); // R2

  AST_ACCEPT_TO_CTL: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqReady & ~reqDrop)) |=> ctlWrEn); // R2

  AST_CTL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |-> ctlWrData[LANE_LSB-1:0] == '0); // R3

  AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[CTL_W-1]) |-> (&ctlWrData[CTL_W-2:LANE_LSB])); // R4

  AST_DROP_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqDrop & ~reqReady) == '0); // R6

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (|reqDrop) |=> !ctlWrEn && !dataWrEn); // R6

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady)); // R7

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn || dataWrEn) |-> reqReady == '0); // R7

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !ctlWrAck) |=> ctlWrEn && $stable(ctlWrData)); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrEn && !dataWrAck) |=> dataWrEn && $stable(dataWrData) && $stable(dataWrAddr)); // R9

endmodule

bind lanewr_seq lanewr_seq_chk #(
  .NREQ(NREQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_LSB(LANE_LSB)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .reqDrop    (reqDrop),
  .ctlWrEn    (ctlWrEn),
  .ctlWrData  (ctlWrData),
  .ctlWrAck   (ctlWrAck),
  .dataWrEn   (dataWrEn),
  .dataWrAddr (dataWrAddr),
  .dataWrData (dataWrData),
  .dataWrAck  (dataWrAck)
);

// File: tb/tb_lanewr_seq.sv
`timescale 1ns/1ps
module tb_lanewr_seq;
  localparam int NREQ = 3;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int LOGN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NREQ-1:0]    reqValid = '0;
  logic [NREQ*AW-1:0] reqAddr  = '0;
  logic [NREQ*DW-1:0] reqData  = '0;
  logic [NREQ*2-1:0]  reqSize  = '0;
  logic [NREQ-1:0]    reqReady, reqDrop;
  logic               ctlWrEn, dataWrEn;
  logic [7:0]         ctlWrData;
  logic               ctlWrAck = 1'b0;
  logic               dataWrAck = 1'b0;
  logic [AW-1:0]      dataWrAddr;
  logic [DW-1:0]      dataWrData;
  logic [1:0]         dataWrSize;

  lanewr_seq #(.NREQ(NREQ), .ADDR_W(AW), .DATA_W(DW), .LANE_LSB(3)) dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData), .reqSize(reqSize),
    .reqReady(reqReady), .reqDrop(reqDrop),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlWrAck(ctlWrAck),
    .dataWrEn(dataWrEn), .dataWrAddr(dataWrAddr), .dataWrData(dataWrData),
    .dataWrSize(dataWrSize), .dataWrAck(dataWrAck)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int ackDelay = 2;
  int lastServed = NREQ - 1;

  logic [7:0]    logCtl  [LOGN];
  logic [DW-1:0] logData [LOGN];
  logic [AW-1:0] logAddr [LOGN];
  logic [1:0]    logSize [LOGN];
  int ctlCnt = 0;
  int dataCnt = 0;

  task automatic chkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Bus responder and protocol monitor, all at the falling edge
  int ctlWait = 0;
  int dataWait = 0;
  logic [7:0]    heldCtl;
  logic [DW-1:0] heldData;
  bit expectCtl = 1'b0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (expectCtl) begin
        chkEq("R2", "control write follows acceptance", 32'(ctlWrEn), 32'd1);
        expectCtl = 1'b0;
      end
      if ((ctlWrEn || dataWrEn) && reqReady != '0)
        chkEq("R7", "ready while pair pending", 32'(reqReady), 32'd0);
      if (ctlWrEn && dataWrEn)
        chkEq("R2", "both enables high", 32'd1, 32'd0);

      if (ctlWrAck) begin
        ctlWrAck = 1'b0;
        ctlWait = 0;
      end else if (ctlWrEn) begin
        if (ctlWait == 0) heldCtl = ctlWrData;
        else chkEq("R9", "control payload held", 32'(ctlWrData), 32'(heldCtl));
        if (ctlWait >= ackDelay) begin
          ctlWrAck = 1'b1;
          if (ctlCnt < LOGN) logCtl[ctlCnt] = ctlWrData;
          ctlCnt++;
        end else ctlWait++;
      end

      if (dataWrAck) begin
        dataWrAck = 1'b0;
        dataWait = 0;
      end else if (dataWrEn) begin
        if (dataWait == 0) heldData = dataWrData;
        else chkEq("R9", "data payload held", dataWrData, heldData);
        if (dataWait >= ackDelay) begin
          dataWrAck = 1'b1;
          chkEq("R2", "one control write before each data write", 32'(ctlCnt), 32'(dataCnt + 2));
          if (dataCnt < LOGN) begin
            logData[dataCnt] = dataWrData;
            logAddr[dataCnt] = dataWrAddr;
            logSize[dataCnt] = dataWrSize;
          end
          dataCnt++;
        end else dataWait++;
      end

      if (|(reqReady & reqValid & ~reqDrop)) expectCtl = 1'b1;
    end
  end

  // Expected values derived from the requirements
  function automatic logic [7:0] expCtl(logic [1:0] s, logic [1:0] o);
    if (s == 2'd0) return 8'h08 << o;
    if (s == 2'd1) return 8'h18 << o;
    return 8'hF8;
  endfunction

  function automatic logic [31:0] expPlace(logic [31:0] d, logic [1:0] s, logic [1:0] o);
    if (s == 2'd0) return (d & 32'hFF) << (8 * o);
    if (s == 2'd1) return (d & 32'hFFFF) << (8 * o);
    return d;
  endfunction

  function automatic int nextOf(int last, logic [NREQ-1:0] m);
    for (int off = 1; off <= NREQ; off++) begin
      int c;
      c = (last + off) % NREQ;
      if (m[c]) return c;
    end
    return -1;
  endfunction

  task automatic issue(int i, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] s, output bit dropped);
    @(posedge clk); #1;
    reqAddr[i*AW +: AW] = a;
    reqData[i*DW +: DW] = d;
    reqSize[i*2 +: 2]   = s;
    reqValid[i]         = 1'b1;
    forever begin
      @(negedge clk);
      if (reqReady[i]) break;
    end
    dropped = reqDrop[i];
    lastServed = i;
    @(posedge clk); #1;
    reqValid[i] = 1'b0;
  endtask

  task automatic waitData(int n);
    while (dataCnt < n) @(negedge clk);
  endtask

  task automatic doWrite(string req, int i, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] s);
    int base;
    bit dr;
    base = dataCnt;
    issue(i, a, d, s, dr);
    chkEq("R6", "well-formed request not dropped", 32'(dr), 32'd0);
    waitData(base + 1);
    chkEq(req, "control value", 32'(logCtl[ctlCnt-1]), 32'(expCtl(s, a[1:0])));
    chkEq("R5", "placed data", logData[base], expPlace(d, s, a[1:0]));
    chkEq("R5", "forwarded address", 32'(logAddr[base]), 32'(a));
    chkEq("R5", "forwarded size", 32'(logSize[base]), 32'(s));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chkEq("R1", "no ready in reset", 32'(reqReady), 32'd0);
    chkEq("R1", "no data write in reset", 32'(dataWrEn), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "init control write pending", 32'(ctlWrEn), 32'd1);
    chkEq("R1", "init control value", 32'(ctlWrData), 32'h78);
    chkEq("R1", "no ready during init", 32'(reqReady), 32'd0);
    while (ctlCnt < 1) @(negedge clk);
    repeat (3) @(negedge clk);
    chkEq("R1", "logged init value", 32'(logCtl[0]), 32'h78);
    chkEq("R1", "single control write", 32'(ctlCnt), 32'd1);
    chkEq("R1", "no data write after init", 32'(dataCnt), 32'd0);
  endtask

  task automatic testBytes();
    ackDelay = 0;
    for (int o = 0; o < 4; o++)
      doWrite("R3", 0, AW'(12'h120 + o), 32'hA5C3_E100 + 32'(o), 2'd0);
  endtask

  task automatic testHalves();
    for (int o = 0; o < 3; o++)
      doWrite("R3", 1, AW'(12'h240 + o), 32'h9876_0000 + 32'(o * 16'h1111 + 16'h0F0F), 2'd1);
  endtask

  task automatic testWords();
    doWrite("R4", 2, 12'h300, 32'hDEAD_BEEF, 2'd2);
    doWrite("R4", 0, 12'h306, 32'h0123_4567, 2'd3);
  endtask

  task automatic testDrop();
    int c0, d0;
    bit dr;
    c0 = ctlCnt;
    d0 = dataCnt;
    issue(2, 12'h1F3, 32'h0000_ABCD, 2'd1, dr);
    chkEq("R6", "drop flag with acceptance", 32'(dr), 32'd1);
    repeat (6) @(negedge clk);
    chkEq("R6", "no control write after drop", 32'(ctlCnt), 32'(c0));
    chkEq("R6", "no data write after drop", 32'(dataCnt), 32'(d0));
    chkEq("R6", "bus quiet after drop", 32'(ctlWrEn | dataWrEn), 32'd0);
    doWrite("R3", 2, 12'h1F2, 32'h0000_ABCD, 2'd1);
  endtask

  task automatic testHold();
    ackDelay = 4;
    doWrite("R9", 1, 12'h081, 32'h0000_005A, 2'd0);
    doWrite("R9", 0, 12'h084, 32'hCAFE_F00D, 2'd2);
  endtask

  task automatic testRotate(logic [NREQ-1:0] mask);
    int order [NREQ];
    int expOrd [NREQ];
    int total, got, base, last;
    logic [NREQ-1:0] m;
    total = $countones(mask);
    base = dataCnt;
    m = mask;
    last = lastServed;
    for (int n = 0; n < total; n++) begin
      expOrd[n] = nextOf(last, m);
      m[expOrd[n]] = 1'b0;
      last = expOrd[n];
    end
    @(posedge clk); #1;
    for (int k = 0; k < NREQ; k++) begin
      if (mask[k]) begin
        reqAddr[k*AW +: AW] = AW'(12'h400 + 4 * k);
        reqData[k*DW +: DW] = 32'h5000_0000 + 32'(k);
        reqSize[k*2 +: 2]   = 2'd2;
        reqValid[k]         = 1'b1;
      end
    end
    got = 0;
    while (got < total) begin
      int clr;
      clr = -1;
      @(negedge clk);
      for (int k = 0; k < NREQ; k++) begin
        if (reqReady[k]) begin
          order[got] = k;
          clr = k;
        end
      end
      if (clr >= 0) begin
        got++;
        lastServed = clr;
        @(posedge clk); #1;
        reqValid[clr] = 1'b0;
      end
    end
    waitData(base + total);
    for (int n = 0; n < total; n++) begin
      chkEq("R8", "grant order", 32'(order[n]), 32'(expOrd[n]));
      chkEq("R8", "data order", logData[base + n], 32'h5000_0000 + 32'(expOrd[n]));
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    testReset();
    testBytes();
    testHalves();
    testWords();
    testDrop();
    testHold();
    ackDelay = 1;
    testRotate(3'b111);
    testRotate(3'b101);
    testRotate(3'b011);
    repeat (5) @(negedge clk);
    report();
  end

endmodule